// File: doc/BRIEF.md
# Memory-Client Hot-Reset Flush Sequencer

This block puts individual clients of a shared memory controller's request path into hot reset and takes them out again. It does this with an ordered handshake, not a reset pulse. Each client has one block bit, which stops it issuing new requests, and one hold bit, which keeps it in hot reset. The client also reports back through one idle bit. When the block accepts an assert command for a client, it first sets the block bit. It then waits, with a bounded and programmable wait, until the client reports that its outstanding requests have drained. Only after that does it fire a one-cycle flush for that client's requests still queued before arbitration and set the hold bit. A deassert command reverses the order: the hold bit clears first, and the block bit clears on the next cycle.

Only one sequence runs at a time. A command that arrives while a sequence is running is refused with a nack pulse. A command that names a client outside the configured range is answered with a no-device code and changes nothing. Each sequence ends with one response pulse that carries a code: 0 for success, 1 for no device, 2 for drain timeout. The block bit vector on `req_block` is the per-client reset status.

States and transitions:
- `ST_IDLE` goes to `ST_BLOCK` on an in-range assert command.
- `ST_IDLE` goes to `ST_RELEASE` on an in-range deassert command.
- `ST_BLOCK` goes to `ST_DRAIN`. This sets the block bit and reloads the timer.
- `ST_DRAIN` goes to `ST_FLUSH` when the client is idle.
- `ST_DRAIN` goes to `ST_IDLE` when the timer is exhausted. This gives the timeout response.
- `ST_FLUSH` goes to `ST_IDLE`. This fires the flush, sets the hold bit and gives the OK response.
- `ST_RELEASE` goes to `ST_UNBLOCK`. This clears the hold bit.
- `ST_UNBLOCK` goes to `ST_IDLE`. This clears the block bit and gives the OK response.

Top module: `hr_flush_seq`

## Requirements
- R1: After reset, `req_block`, `client_hold` and `queue_flush` are all zero, and `busy`, `resp_valid` and `cmd_nack` are low.
- R2: For an in-range assert command accepted at clock edge E, `busy` is high after E and the client's `req_block` bit is set after edge E+1, before any drain check.
- R3: While the selected client's `client_idle` bit is low during the drain wait, the client's hold bit stays clear, no flush fires, and no response is given.
- R4: The first drain-wait edge that sees `client_idle` high for the client leads to one following edge. After that edge, `queue_flush` pulses for exactly one cycle on that client only, `client_hold` sets for that client, and a response with code 0 (OK) is given.
- R5: For a deassert command accepted at edge E, the client's hold bit clears after E+1. Its block bit clears after E+2, together with a response with code 0.
- R6: A sequence changes only the addressed client's bits. On any edge at most one bit of `req_block` changes.
- R7: The drain timer reloads from `drain_limit` at the start of every assert. If the client is still not idle after `drain_limit`+1 drain checks, the response code is 2 (timeout), the block bit stays set and the hold bit stays clear.
- R8: A command with `cmd_id` >= N, sampled while not busy, gives a response with code 1 (no device) on the next cycle. It changes no bit and does not set `busy`.
- R9: A command sampled while `busy` is high is ignored, and `cmd_nack` pulses on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, sampled on each clock edge |
| cmd_assert | input | 1 | 1 = enter hot reset, 0 = leave hot reset |
| cmd_id | input | IDW | Client index; values >= N are out of range |
| drain_limit | input | TW | Drain timer reload value |
| client_idle | input | N | Per-client drained indication |
| req_block | output | N | Per-client request block bit (reset status) |
| client_hold | output | N | Per-client hot-reset hold |
| queue_flush | output | N | One-cycle pre-arbitration queue flush |
| busy | output | 1 | A sequence is in progress |
| cmd_nack | output | 1 | Command refused because busy |
| resp_valid | output | 1 | Completion pulse |
| resp_code | output | 2 | 0 OK, 1 no device, 2 timeout |

## Verification
The bench uses several patterns:
- A client that is already idle when the command arrives. This shows that the flush and the hold wait for the block step and one drain check.
- A client that drains late. This separates waiting on the idle bit from a fixed delay.
- A client that never drains, followed by a second assert on the same client with a longer limit. This separates a reload of the timer at each assert from a single reload at reset.
- Commands that are out of range or that arrive while busy, with several clients already held. These show that the other clients' bits do not move and that refused commands leave no trace.

// File: rtl/hr_pkg.sv
package hr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_BLOCK   = 3'd1,
        ST_DRAIN   = 3'd2,
        ST_FLUSH   = 3'd3,
        ST_RELEASE = 3'd4,
        ST_UNBLOCK = 3'd5
    } hr_state_e;

    typedef enum logic [1:0] {
        RC_OK      = 2'd0,
        RC_NODEV   = 2'd1,
        RC_TIMEOUT = 2'd2
    } hr_resp_e;
endpackage

// File: rtl/hr_drain_timer.sv
module hr_drain_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          dec,
    input  logic [TW-1:0] limit,
    output logic          zero
);
    logic [TW-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= limit;
        end else if (dec && count_q != '0) begin
            count_q <= count_q - 1'b1;
        end
    end

    assign zero = (count_q == '0);
endmodule

// File: rtl/hr_client_bits.sv
module hr_client_bits #(
    parameter int N  = 8,
    parameter int SW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] sel,
    input  logic          set_block,
    input  logic          clr_block,
    input  logic          set_hold,
    input  logic          clr_hold,
    input  logic          fire_flush,
    output logic [N-1:0]  block_q,
    output logic [N-1:0]  hold_q,
    output logic [N-1:0]  flush_q
);
    for (genvar i = 0; i < N; i++) begin : g_client
        logic hit;
        assign hit = (sel == SW'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                block_q[i] <= 1'b0;
                hold_q[i]  <= 1'b0;
                flush_q[i] <= 1'b0;
            end else begin
                flush_q[i] <= fire_flush && hit;
                if (hit && set_block) begin
                    block_q[i] <= 1'b1;
                end else if (hit && clr_block) begin
                    block_q[i] <= 1'b0;
                end
                if (hit && set_hold) begin
                    hold_q[i] <= 1'b1;
                end else if (hit && clr_hold) begin
                    hold_q[i] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/hr_seq_fsm.sv
module hr_seq_fsm
    import hr_pkg::*;
#(
    parameter int N   = 8,
    parameter int SW  = 3,
    parameter int IDW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_valid,
    input  logic           cmd_assert,
    input  logic [IDW-1:0] cmd_id,
    input  logic [N-1:0]   client_idle,
    input  logic           tmo_zero,
    output hr_state_e      state_o,
    output logic [SW-1:0]  sel_o,
    output logic           tmr_load,
    output logic           tmr_dec,
    output logic           set_block,
    output logic           clr_block,
    output logic           set_hold,
    output logic           clr_hold,
    output logic           fire_flush,
    output logic           resp_fire,
    output hr_resp_e       resp_code_nxt,
    output logic           nack_fire
);
    hr_state_e     state_q, state_d;
    logic [SW-1:0] sel_q;
    logic          id_ok;
    logic          sel_idle;

    assign id_ok    = (cmd_id < IDW'(N));
    assign sel_idle = client_idle[sel_q];
    assign state_o  = state_q;
    assign sel_o    = sel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && cmd_valid && id_ok) begin
                sel_q <= cmd_id[SW-1:0];
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid && id_ok) begin
                    state_d = cmd_assert ? ST_BLOCK : ST_RELEASE;
                end
            end
            ST_BLOCK:   state_d = ST_DRAIN;
            ST_DRAIN: begin
                if (sel_idle || tmo_zero) begin
                    state_d = sel_idle ? ST_FLUSH : ST_IDLE;
                end
            end
            ST_FLUSH:   state_d = ST_IDLE;
            ST_RELEASE: state_d = ST_UNBLOCK;
            ST_UNBLOCK: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        tmr_load      = 1'b0;
        tmr_dec       = 1'b0;
        set_block     = 1'b0;
        clr_block     = 1'b0;
        set_hold      = 1'b0;
        clr_hold      = 1'b0;
        fire_flush    = 1'b0;
        resp_fire     = 1'b0;
        resp_code_nxt = RC_OK;
        nack_fire     = (state_q != ST_IDLE) && cmd_valid;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid && !id_ok) begin
                    resp_fire     = 1'b1;
                    resp_code_nxt = RC_NODEV;
                end
            end
            ST_BLOCK: begin
                set_block = 1'b1;
                tmr_load  = 1'b1;
            end
            ST_DRAIN: begin
                if (!sel_idle) begin
                    if (tmo_zero) begin
                        resp_fire     = 1'b1;
                        resp_code_nxt = RC_TIMEOUT;
                    end else begin
                        tmr_dec = 1'b1;
                    end
                end
            end
            ST_FLUSH: begin
                fire_flush = 1'b1;
                set_hold   = 1'b1;
                resp_fire  = 1'b1;
            end
            ST_RELEASE: clr_hold = 1'b1;
            ST_UNBLOCK: begin
                clr_block = 1'b1;
                resp_fire = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/hr_flush_seq.sv
module hr_flush_seq
    import hr_pkg::*;
#(
    parameter int N   = 8,
    parameter int TW  = 8,
    parameter int SW  = (N > 1) ? $clog2(N) : 1,
    parameter int IDW = SW + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_valid,
    input  logic           cmd_assert,
    input  logic [IDW-1:0] cmd_id,
    input  logic [TW-1:0]  drain_limit,
    input  logic [N-1:0]   client_idle,
    output logic [N-1:0]   req_block,
    output logic [N-1:0]   client_hold,
    output logic [N-1:0]   queue_flush,
    output logic           busy,
    output logic           cmd_nack,
    output logic           resp_valid,
    output logic [1:0]     resp_code
);
    hr_state_e     state;
    logic [SW-1:0] sel;
    logic          tmr_load, tmr_dec, tmo_zero;
    logic          set_block, clr_block, set_hold, clr_hold, fire_flush;
    logic          resp_fire, nack_fire;
    hr_resp_e      resp_code_nxt;

    hr_seq_fsm #(.N(N), .SW(SW), .IDW(IDW)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_assert   (cmd_assert),
        .cmd_id       (cmd_id),
        .client_idle  (client_idle),
        .tmo_zero     (tmo_zero),
        .state_o      (state),
        .sel_o        (sel),
        .tmr_load     (tmr_load),
        .tmr_dec      (tmr_dec),
        .set_block    (set_block),
        .clr_block    (clr_block),
        .set_hold     (set_hold),
        .clr_hold     (clr_hold),
        .fire_flush   (fire_flush),
        .resp_fire    (resp_fire),
        .resp_code_nxt(resp_code_nxt),
        .nack_fire    (nack_fire)
    );

    hr_drain_timer #(.TW(TW)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .load (tmr_load),
        .dec  (tmr_dec),
        .limit(drain_limit),
        .zero (tmo_zero)
    );

    hr_client_bits #(.N(N), .SW(SW)) u_bits (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .set_block (set_block),
        .clr_block (clr_block),
        .set_hold  (set_hold),
        .clr_hold  (clr_hold),
        .fire_flush(fire_flush),
        .block_q   (req_block),
        .hold_q    (client_hold),
        .flush_q   (queue_flush)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_code  <= RC_OK;
            cmd_nack   <= 1'b0;
        end else begin
            resp_valid <= resp_fire;
            cmd_nack   <= nack_fire;
            if (resp_fire) begin
                resp_code <= resp_code_nxt;
            end
        end
    end

    assign busy = (state != ST_IDLE);
endmodule

// File: rtl/hr_flush_seq_chk.sv
module hr_flush_seq_chk #(
    parameter int N   = 8,
    parameter int IDW = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cmd_valid,
    input logic [IDW-1:0] cmd_id,
    input logic [N-1:0]   req_block,
    input logic [N-1:0]   client_hold,
    input logic [N-1:0]   queue_flush,
    input logic           busy,
    input logic           cmd_nack,
    input logic           resp_valid,
    input logic [1:0]     resp_code
);
    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_FLUSH_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(queue_flush)); // R4
    AST_FLUSH_WITH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (|queue_flush) |-> ((queue_flush & ~client_hold) == '0) && resp_valid && resp_code == 2'd0); // R4
    AST_HOLD_AFTER_BLOCK: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        ((client_hold & ~$past(client_hold) & ~$past(req_block)) == '0)); // R2
    AST_UNBLOCK_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (($past(req_block) & ~req_block & $past(client_hold)) == '0)); // R5
    AST_ONE_BIT_STEP: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        $countones(req_block ^ $past(req_block)) <= 1); // R6
    AST_NODEV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_id >= IDW'(N)) |=>
            resp_valid && resp_code == 2'd1 && !busy && $stable(req_block) && $stable(client_hold)); // R8
    AST_NACK_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && busy) |=> cmd_nack); // R9
endmodule

bind hr_flush_seq hr_flush_seq_chk #(.N(N), .IDW(IDW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_id     (cmd_id),
    .req_block  (req_block),
    .client_hold(client_hold),
    .queue_flush(queue_flush),
    .busy       (busy),
    .cmd_nack   (cmd_nack),
    .resp_valid (resp_valid),
    .resp_code  (resp_code)
);

// File: tb/test_hr_flush_seq.sv
`timescale 1ns/1ps
module test_hr_flush_seq;
    localparam int N   = 8;
    localparam int TW  = 8;
    localparam int IDW = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cmd_valid = 1'b0;
    logic           cmd_assert = 1'b0;
    logic [IDW-1:0] cmd_id = '0;
    logic [TW-1:0]  drain_limit = 8'd10;
    logic [N-1:0]   client_idle = '1;
    logic [N-1:0]   req_block, client_hold, queue_flush;
    logic           busy, cmd_nack, resp_valid;
    logic [1:0]     resp_code;

    always #2 clk = ~clk;

    hr_flush_seq #(.N(N), .TW(TW)) i_hr_flush_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_assert(cmd_assert),
        .cmd_id(cmd_id), .drain_limit(drain_limit), .client_idle(client_idle),
        .req_block(req_block), .client_hold(client_hold), .queue_flush(queue_flush),
        .busy(busy), .cmd_nack(cmd_nack), .resp_valid(resp_valid), .resp_code(resp_code)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cycles = 0;
    bit    done = 0;
    string cur_req = "R1";

    // Behavioural reference: phase 0 idle, 1 block, 2 drain, 3 flush, 4 release, 5 unblock
    int         ph = 0;
    int         cid = 0;
    int         tmr = 0;
    logic [N-1:0] m_blk = '0, m_hold = '0, m_fl = '0;
    logic       m_rv = 0, m_nack = 0;
    int         m_rc = 0;
    int         last_rc = -1;

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; cid = 0; tmr = 0;
            m_blk = '0; m_hold = '0; m_fl = '0; m_rv = 0; m_nack = 0;
        end else begin
            m_fl = '0; m_rv = 0;
            m_nack = (ph != 0) && cmd_valid;
            case (ph)
                0: if (cmd_valid) begin
                       if (int'(cmd_id) >= N) begin m_rv = 1; m_rc = 1; end
                       else begin cid = int'(cmd_id); ph = cmd_assert ? 1 : 4; end
                   end
                1: begin m_blk[cid] = 1'b1; tmr = int'(drain_limit); ph = 2; end
                2: if (client_idle[cid]) ph = 3;
                   else if (tmr == 0) begin m_rv = 1; m_rc = 2; ph = 0; end
                   else tmr = tmr - 1;
                3: begin m_fl[cid] = 1'b1; m_hold[cid] = 1'b1; m_rv = 1; m_rc = 0; ph = 0; end
                4: begin m_hold[cid] = 1'b0; ph = 5; end
                5: begin m_blk[cid] = 1'b0; m_rv = 1; m_rc = 0; ph = 0; end
                default: ph = 0;
            endcase
            if (resp_valid) last_rc = int'(resp_code);
        end
    end

    task automatic fail(string req, string what, int act, int exp);
        n_bad++;
        $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_cmp++;
            if (req_block !== m_blk)             fail(cur_req, "req_block", int'(req_block), int'(m_blk));
            else if (client_hold !== m_hold)     fail(cur_req, "client_hold", int'(client_hold), int'(m_hold));
            else if (queue_flush !== m_fl)       fail(cur_req, "queue_flush", int'(queue_flush), int'(m_fl));
            else if (busy !== (ph != 0))         fail(cur_req, "busy", int'(busy), int'(ph != 0));
            else if (cmd_nack !== m_nack)        fail(cur_req, "cmd_nack", int'(cmd_nack), int'(m_nack));
            else if (resp_valid !== m_rv)        fail(cur_req, "resp_valid", int'(resp_valid), int'(m_rv));
            else if (m_rv && int'(resp_code) != m_rc) fail(cur_req, "resp_code", int'(resp_code), m_rc);
        end
    end

    task automatic expect_eq(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) fail(req, what, act, exp);
    endtask

    task automatic send(bit asrt, int id);
        @(posedge clk); #1;
        cmd_valid = 1'b1; cmd_assert = asrt; cmd_id = IDW'(id);
        @(posedge clk); #1;
        cmd_valid = 1'b0;
    endtask

    task automatic idle_cycles(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected<=20000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        idle_cycles(3);
        @(negedge clk);
        cur_req = "R1";
        expect_eq("R1", "block in reset", int'(req_block), 0);
        expect_eq("R1", "busy in reset", int'(busy), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        expect_eq("R1", "hold after reset", int'(client_hold), 0);
        expect_eq("R1", "nack after reset", int'(cmd_nack), 0);

        cur_req = "R2";
        send(1'b1, 2);
        @(negedge clk);
        expect_eq("R2", "busy after accept", int'(busy), 1);
        idle_cycles(6);
        cur_req = "R4";
        expect_eq("R4", "hold client 2", int'(client_hold), 32'h04);
        expect_eq("R4", "last resp code", last_rc, 0);

        cur_req = "R3";
        client_idle[5] = 1'b0; drain_limit = 8'd20;
        send(1'b1, 5);
        idle_cycles(8);
        expect_eq("R3", "no hold while draining", int'(client_hold[5]), 0);
        client_idle[5] = 1'b1;
        idle_cycles(6);
        expect_eq("R4", "hold client 5", int'(client_hold), 32'h24);

        cur_req = "R5";
        send(1'b0, 2);
        idle_cycles(6);
        expect_eq("R5", "block after release", int'(req_block), 32'h20);
        expect_eq("R5", "hold after release", int'(client_hold), 32'h20);

        cur_req = "R7";
        client_idle[0] = 1'b0; drain_limit = 8'd3;
        send(1'b1, 0);
        idle_cycles(12);
        expect_eq("R7", "timeout code", last_rc, 2);
        expect_eq("R7", "block kept", int'(req_block[0]), 1);
        expect_eq("R7", "hold clear", int'(client_hold[0]), 0);
        drain_limit = 8'd10;
        send(1'b1, 0);
        idle_cycles(5);
        client_idle[0] = 1'b1;
        idle_cycles(6);
        expect_eq("R7", "reload then success", last_rc, 0);
        expect_eq("R7", "hold client 0", int'(client_hold[0]), 1);

        cur_req = "R8";
        send(1'b1, 9);
        idle_cycles(3);
        expect_eq("R8", "nodev code", last_rc, 1);
        send(1'b0, 8);
        idle_cycles(3);
        expect_eq("R8", "bits unchanged", int'(req_block), 32'h21);

        cur_req = "R9";
        client_idle[3] = 1'b0;
        send(1'b1, 3);
        send(1'b0, 5);
        idle_cycles(4);
        client_idle[3] = 1'b1;
        idle_cycles(6);
        expect_eq("R9", "refused command left client 5", int'(client_hold[5]), 1);

        cur_req = "R6";
        send(1'b1, 7);
        idle_cycles(6);
        send(1'b0, 0);
        idle_cycles(6);
        expect_eq("R6", "only addressed bits moved", int'(req_block), 32'hA8);
        expect_eq("R6", "hold set", int'(client_hold), 32'hA8);

        idle_cycles(4);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule